// File: doc/BRIEF.md
# Jittered PWM Generator with Soft Start

This block is the digital timing core of a fixed-frequency, current-mode flyback controller. It divides the system clock into switching periods, turns the power switch on at the start of every period, and turns it off when the first of three comparator flags asserts: the PWM comparator, the soft-start comparator or the current-limit comparator. A maximum-duty limit forces the switch off for the last quarter of each period, whatever the flags do. The current-sense flags are ignored for a short blanking window after each turn-on.

After the supply-good input rises, a 32-step soft-start counter raises the permitted on-time from zero to the full duty limit. Once the last step is reached, the period stops being fixed and follows a slow triangular sweep around the nominal length to spread the switching spectrum. Dropping the supply-good input or pulsing the restart request clears the soft start so that it runs again from step zero. All durations are parameters in system clock cycles. The defaults are scaled down for simulation: a 100-clock period, a ±4-clock sweep, a 4-clock blanking window and 250 clocks per soft-start step.

The control state machine has three states. ST_IDLE holds the core off. ST_SOFT runs the soft start with a fixed period. ST_RUN releases the duty limit to its maximum and enables the jitter sweep. The transitions are as follows. IDLE→SOFT happens when en is high. SOFT→RUN happens when the soft start completes. RUN→SOFT happens on restart. SOFT and RUN both go to IDLE when en goes low.

Top module: `pwm_jitter_core`

## Requirements
- R1: While rst_n or en is low, gate is 0, ss_step is 0 and ss_done is 0. When en falls, gate is 0 from the next clock edge on.
- R2: Before ss_done is set, every switching period lasts exactly PERIOD_NOM clocks (100). Measured from one gate rising edge to the next, the interval is 100.
- R3: The gate on-time in a period of P clocks never exceeds floor(P*DUTY_NUM/DUTY_DEN), which is floor(3P/4). When no flag asserts after soft start, the on-time equals that value.
- R4: ss_step starts at 0 and increases by 1 every SS_STEP_CYC clocks (250), up to SS_STEPS (32), where ss_done becomes 1. The first step arrives 250 clocks after the cycle in which the core leaves ST_IDLE. At step k the on-time is floor(75*k/32) clocks with the defaults, so step 0 produces no gate pulse.
- R5: The period sweep is active only after ss_done. Each period then lies within PERIOD_NOM±JIT_SPAN (96..104). Consecutive periods differ by at most JIT_STEP (1). The sweep reaches both limits.
- R6: Each of flag_pwm, flag_ss and flag_ilim ends the pulse. A flag sampled high at the edge where the pulse is in its j-th clock, with j > LEB_CYC, drives gate low at that edge, so the on-time is j clocks.
- R7: Flags sampled during the first LEB_CYC clocks (4) of the on-time are ignored. A flag held from turn-on gives an on-time of LEB_CYC+1 clocks.
- R8: A restart pulse sampled at an edge drives gate low, ss_step to 0 and ss_done to 0 at that edge. Soft start then reruns from step 0.
- R9: After en returns high, soft start begins again at step 0, and step 1 arrives SS_STEP_CYC clocks after the core leaves ST_IDLE.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Supply-good flag from the undervoltage monitor |
| restart | input | 1 | Request to rerun soft start (auto-restart attempt) |
| flag_pwm | input | 1 | PWM comparator trip |
| flag_ss | input | 1 | Soft-start comparator trip |
| flag_ilim | input | 1 | Current-limit comparator trip |
| gate | output | 1 | Power switch drive |
| ss_done | output | 1 | Soft start complete |
| ss_step | output | $clog2(SS_STEPS+1) | Current soft-start step, 0..SS_STEPS |

## Verification
Gate responses follow a fixed schedule:
- Gate rises at the edge where the period counter is at 0.
- Gate falls at the first edge that samples a qualified flag, or at the edge where the on-time limit is reached.
- The effects of en and restart appear at the first edge after they are driven.

The bench drives inputs and samples outputs on the falling clock edge. Each pulse is measured as a count of falling edges, both for the on-time and for the interval to the next rise. A flag applied at falling edge k is therefore seen at the (k+1)-th clock of the pulse, and the expected width is computed from that mapping. Soft-start timing is counted from the falling edge at which en is raised. The first step is due 251 falling edges later: one edge to leave ST_IDLE, then 250 step clocks.

// File: rtl/pwm_jit_pkg.sv
package pwm_jit_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SOFT = 2'd1,
        ST_RUN  = 2'd2
    } core_state_t;

endpackage

// File: rtl/pwm_period_gen.sv
// Switching period counter with a triangular sweep of the period length.
module pwm_period_gen #(
    parameter int NOM  = 100,
    parameter int SPAN = 4,
    parameter int STEP = 1,
    parameter int PW   = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          jit_en,
    output logic [PW-1:0] cnt,
    output logic [PW-1:0] per,
    output logic          cyc_start
);
    localparam logic [PW-1:0] P_NOM  = PW'(NOM);
    localparam logic [PW-1:0] P_HI   = PW'(NOM + SPAN);
    localparam logic [PW-1:0] P_LO   = PW'(NOM - SPAN);
    localparam logic [PW-1:0] P_STEP = PW'(STEP);

    logic [PW-1:0] cnt_q;
    logic [PW-1:0] per_q;
    logic          dir_up;
    logic          wrap;

    assign wrap = (cnt_q == per_q - 1'b1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            per_q  <= P_NOM;
            dir_up <= 1'b1;
        end else if (clr) begin
            cnt_q  <= '0;
            per_q  <= P_NOM;
            dir_up <= 1'b1;
        end else begin
            cnt_q <= wrap ? '0 : cnt_q + 1'b1;
            if (wrap) begin
                if (!jit_en) begin
                    per_q  <= P_NOM;
                    dir_up <= 1'b1;
                end else if (dir_up) begin
                    if (per_q + P_STEP >= P_HI) begin
                        per_q  <= P_HI;
                        dir_up <= 1'b0;
                    end else begin
                        per_q <= per_q + P_STEP;
                    end
                end else begin
                    if (per_q <= P_LO + P_STEP) begin
                        per_q  <= P_LO;
                        dir_up <= 1'b1;
                    end else begin
                        per_q <= per_q - P_STEP;
                    end
                end
            end
        end
    end

    assign cnt       = cnt_q;
    assign per       = per_q;
    assign cyc_start = (cnt_q == '0);

endmodule

// File: rtl/pwm_softstart.sv
// Step counter that raises the duty limit in equal time slices.
module pwm_softstart #(
    parameter int STEPS    = 32,
    parameter int STEP_CYC = 250,
    parameter int SW       = 6,
    parameter int TW       = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          run,
    output logic [SW-1:0] step,
    output logic          done
);
    localparam logic [TW-1:0] TICK_LAST = TW'(STEP_CYC - 1);
    localparam logic [SW-1:0] STEP_LAST = SW'(STEPS);

    logic [TW-1:0] tick_q;
    logic [SW-1:0] step_q;

    assign done = (step_q == STEP_LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tick_q <= '0;
            step_q <= '0;
        end else if (clr) begin
            tick_q <= '0;
            step_q <= '0;
        end else if (run && !done) begin
            if (tick_q == TICK_LAST) begin
                tick_q <= '0;
                step_q <= step_q + 1'b1;
            end else begin
                tick_q <= tick_q + 1'b1;
            end
        end
    end

    assign step = step_q;

endmodule

// File: rtl/pwm_gate_latch.sv
// Gate latch: set at period start, cleared by limit or a qualified flag.
module pwm_gate_latch #(
    parameter int PW  = 7,
    parameter int LEB = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          kill,
    input  logic          cyc_start,
    input  logic [PW-1:0] cnt,
    input  logic [PW-1:0] lim,
    input  logic          flag_any,
    output logic          gate
);
    localparam logic [PW-1:0] LEB_C = PW'(LEB);

    logic gate_q;
    logic blank_over;

    assign blank_over = (cnt > LEB_C);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gate_q <= 1'b0;
        end else if (kill) begin
            gate_q <= 1'b0;
        end else if (cyc_start) begin
            gate_q <= (lim != '0);
        end else if (gate_q && ((cnt >= lim) || (flag_any && blank_over))) begin
            gate_q <= 1'b0;
        end
    end

    assign gate = gate_q;

endmodule

// File: rtl/pwm_jitter_core.sv
module pwm_jitter_core
    import pwm_jit_pkg::*;
#(
    parameter int PERIOD_NOM  = 100,
    parameter int JIT_SPAN    = 4,
    parameter int JIT_STEP    = 1,
    parameter int DUTY_NUM    = 3,
    parameter int DUTY_DEN    = 4,
    parameter int LEB_CYC     = 4,
    parameter int SS_STEPS    = 32,
    parameter int SS_STEP_CYC = 250
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           en,
    input  logic                           restart,
    input  logic                           flag_pwm,
    input  logic                           flag_ss,
    input  logic                           flag_ilim,
    output logic                           gate,
    output logic                           ss_done,
    output logic [$clog2(SS_STEPS+1)-1:0]  ss_step
);
    localparam int PW = $clog2(PERIOD_NOM + JIT_SPAN + JIT_STEP + 1);
    localparam int SW = $clog2(SS_STEPS + 1);
    localparam int TW = $clog2(SS_STEP_CYC);
    localparam int MW = PW + $clog2(DUTY_NUM + 1);
    localparam int LW = MW + SW;

    core_state_t state_q, state_d;

    logic          clr_all;
    logic          jit_en;
    logic          ss_run;
    logic          cyc_start;
    logic [PW-1:0] cyc_cnt;
    logic [PW-1:0] cur_per;
    logic [PW-1:0] max_on;
    logic [PW-1:0] on_lim;
    logic [MW-1:0] duty_prod;
    logic [LW-1:0] soft_prod;
    logic          flag_any;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (en) state_d = ST_SOFT;
            ST_SOFT: begin
                if (!en)                       state_d = ST_IDLE;
                else if (ss_done && !restart)  state_d = ST_RUN;
            end
            ST_RUN: begin
                if (!en)          state_d = ST_IDLE;
                else if (restart) state_d = ST_SOFT;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State outputs
    always_comb begin
        clr_all = !en || restart;
        jit_en  = 1'b0;
        ss_run  = 1'b0;
        unique case (state_q)
            ST_IDLE: clr_all = 1'b1;
            ST_SOFT: ss_run  = 1'b1;
            ST_RUN:  jit_en  = 1'b1;
            default: clr_all = 1'b1;
        endcase
    end

    pwm_period_gen #(
        .NOM (PERIOD_NOM),
        .SPAN(JIT_SPAN),
        .STEP(JIT_STEP),
        .PW  (PW)
    ) u_period (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (clr_all),
        .jit_en   (jit_en),
        .cnt      (cyc_cnt),
        .per      (cur_per),
        .cyc_start(cyc_start)
    );

    pwm_softstart #(
        .STEPS   (SS_STEPS),
        .STEP_CYC(SS_STEP_CYC),
        .SW      (SW),
        .TW      (TW)
    ) u_soft (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (clr_all),
        .run  (ss_run),
        .step (ss_step),
        .done (ss_done)
    );

    // Duty limits: full limit follows the live period length
    assign duty_prod = MW'(cur_per) * MW'(DUTY_NUM);
    assign max_on    = PW'(duty_prod / MW'(DUTY_DEN));
    assign soft_prod = LW'(max_on) * LW'(ss_step);

    always_comb begin
        if (state_q == ST_RUN) on_lim = max_on;
        else                   on_lim = PW'(soft_prod / LW'(SS_STEPS));
    end

    assign flag_any = flag_pwm || flag_ss || flag_ilim;

    pwm_gate_latch #(
        .PW (PW),
        .LEB(LEB_CYC)
    ) u_gate (
        .clk      (clk),
        .rst_n    (rst_n),
        .kill     (clr_all),
        .cyc_start(cyc_start),
        .cnt      (cyc_cnt),
        .lim      (on_lim),
        .flag_any (flag_any),
        .gate     (gate)
    );

endmodule

// File: rtl/pwm_jitter_chk.sv
module pwm_jitter_chk #(
    parameter int PW    = 7,
    parameter int SW    = 6,
    parameter int NOM   = 100,
    parameter int SPAN  = 4,
    parameter int LEB   = 4,
    parameter int STEPS = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          en,
    input logic          restart,
    input logic          gate,
    input logic [SW-1:0] ss_step,
    input logic          ss_done,
    input logic [PW-1:0] cnt,
    input logic [PW-1:0] lim,
    input logic [PW-1:0] per
);
    localparam logic [PW-1:0] C_NOM = PW'(NOM);
    localparam logic [PW-1:0] C_HI  = PW'(NOM + SPAN);
    localparam logic [PW-1:0] C_LO  = PW'(NOM - SPAN);
    localparam logic [PW-1:0] C_LEB = PW'(LEB);
    localparam logic [SW-1:0] C_STP = SW'(STEPS);

    p_uvlo_gate_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (!gate && ss_step == '0 && !ss_done));

    p_rise_at_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gate) |-> (cnt == PW'(1)));

    p_max_duty_r3: assert property (@(posedge clk) disable iff (!rst_n)
        gate |-> (cnt != '0 && cnt <= lim));

    p_step_bounded_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ss_step <= C_STP) && (ss_done == (ss_step == C_STP)));

    p_step_monotone_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ss_step != $past(ss_step)) |-> (ss_step == $past(ss_step) + 1'b1 || ss_step == '0));

    p_jitter_off_soft_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !ss_done |-> (per == C_NOM));

    p_period_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (per >= C_LO) && (per <= C_HI));

    p_blanking_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(gate) && $past(en) && !$past(restart)) |->
            ($past(cnt) > C_LEB || $past(cnt) >= $past(lim)));

    p_restart_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (!gate && ss_step == '0 && !ss_done));

endmodule

bind pwm_jitter_core pwm_jitter_chk #(
    .PW   (PW),
    .SW   (SW),
    .NOM  (PERIOD_NOM),
    .SPAN (JIT_SPAN),
    .LEB  (LEB_CYC),
    .STEPS(SS_STEPS)
) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .en     (en),
    .restart(restart),
    .gate   (gate),
    .ss_step(ss_step),
    .ss_done(ss_done),
    .cnt    (cyc_cnt),
    .lim    (on_lim),
    .per    (cur_per)
);

// File: tb/tb_pwm_jitter_core.sv
`timescale 1ns/1ps
module tb_pwm_jitter_core;
    localparam int NOM   = 100;
    localparam int SPAN  = 4;
    localparam int JSTEP = 1;
    localparam int LEB   = 4;
    localparam int STEPS = 32;
    localparam int SCYC  = 250;
    localparam int NVEC  = 8;
    // flag vectors: {flag select (0 pwm, 1 ss, 2 ilim), start negedge, hold length}
    // R7: rows 0,1,6 ; R6: rows 2,3,4,5,7
    localparam int VEC [NVEC][3] = '{
        '{0, 0, 80}, '{1, 0, 3}, '{2, 10, 1}, '{0, 20, 2},
        '{1, 30, 5}, '{2, 4, 1}, '{0, 3, 1}, '{1, 72, 10}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0, en = 1'b0, restart = 1'b0;
    logic f_pwm = 1'b0, f_ss = 1'b0, f_ilim = 1'b0;
    logic gate, ss_done;
    logic [5:0] ss_step;

    int n_chk = 0;
    int n_fail = 0;
    bit over = 0;

    always #2.5 clk = ~clk;

    pwm_jitter_core #(
        .PERIOD_NOM(NOM), .JIT_SPAN(SPAN), .JIT_STEP(JSTEP), .DUTY_NUM(3),
        .DUTY_DEN(4), .LEB_CYC(LEB), .SS_STEPS(STEPS), .SS_STEP_CYC(SCYC)
    ) dut (
        .clk(clk), .rst_n(rst_n), .en(en), .restart(restart),
        .flag_pwm(f_pwm), .flag_ss(f_ss), .flag_ilim(f_ilim),
        .gate(gate), .ss_done(ss_done), .ss_step(ss_step)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic set_flags(input int sel, input bit v);
        f_pwm  = (sel == 0) && v;
        f_ss   = (sel == 1) && v;
        f_ilim = (sel == 2) && v;
    endtask

    task automatic wait_rise();
        int g = 0;
        while (gate && g < 1000) begin @(negedge clk); g++; end
        while (!gate && g < 1000) begin @(negedge clk); g++; end
    endtask

    task automatic wait_step(input int k, output int t, output bit saw);
        t = 0; saw = 0;
        while (ss_step != 6'(k) && t < 20000) begin
            @(negedge clk); t++;
            if (gate) saw = 1;
        end
    endtask

    // Measure one pulse: width w and interval p to next rise, in clocks
    task automatic pulse(input int sel, input int s, input int h, input bit at_rise,
                         output int w, output int p);
        int k = 0;
        if (!at_rise) wait_rise();
        w = 0;
        while (gate && k < 400) begin
            set_flags(sel, (k >= s) && (k < s + h));
            @(negedge clk); w++; k++;
        end
        set_flags(sel, 1'b0);
        while (!gate && k < 400) begin @(negedge clk); k++; end
        p = k;
    endtask

    task automatic finish_run();
        if (!over) begin
            over = 1;
            $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        finish_run();
    end

    initial begin
        int t, w, p, lim, j0, exp, pmin, pmax, pprev, dmax;
        bit saw;
        repeat (5) @(negedge clk);
        chk("R1 gate in reset", int'(gate), 0);
        chk("R1 step in reset", int'(ss_step), 0);
        chk("R1 done in reset", int'(ss_done), 0);
        rst_n = 1'b1;
        saw = 0;
        for (int i = 0; i < 20; i++) begin @(negedge clk); if (gate) saw = 1; end
        chk("R1 gate low while en low", int'(saw), 0);

        // Soft start
        en = 1'b1;
        wait_step(1, t, saw);
        chk("R4 no pulse at step 0", int'(saw), 0);
        chk("R4 first step delay", t, SCYC + 1);
        wait_step(2, t, saw);
        chk("R4 step spacing", t, SCYC);
        pulse(0, 0, 0, 1'b0, w, p);
        chk("R4 width at step 2", w, (75 * 2) / 32);
        chk("R2 period in soft start", p, NOM);
        foreach (VEC[0][i]) begin end
        for (int ki = 0; ki < 3; ki++) begin
            int k;
            k = (ki == 0) ? 5 : (ki == 1) ? 16 : 31;
            wait_step(k, t, saw);
            pulse(0, 0, 0, 1'b0, w, p);
            chk($sformatf("R4 width at step %0d", k), w, (75 * k) / 32);
            chk("R2 period in soft start", p, NOM);
        end
        while (!ss_done) @(negedge clk);
        chk("R4 final step value", int'(ss_step), STEPS);

        // Jitter sweep and full duty
        pmin = 1000; pmax = 0; pprev = NOM; dmax = 0;
        for (int i = 0; i < 24; i++) begin
            pulse(0, 0, 0, (i != 0), w, p);
            if (w != (p * 3) / 4) chk("R3 full duty width", w, (p * 3) / 4);
            if (p < pmin) pmin = p;
            if (p > pmax) pmax = p;
            if (i != 0 && ((p - pprev) > dmax)) dmax = p - pprev;
            if (i != 0 && ((pprev - p) > dmax)) dmax = pprev - p;
            pprev = p;
        end
        chk("R3 full duty width last", w, (p * 3) / 4);
        chk("R5 shortest period", pmin, NOM - SPAN);
        chk("R5 longest period", pmax, NOM + SPAN);
        chk("R5 period change per cycle", dmax, JSTEP);

        // Flag vectors
        for (int i = 0; i < NVEC; i++) begin
            pulse(VEC[i][0], VEC[i][1], VEC[i][2], 1'b0, w, p);
            lim = (p * 3) / 4;
            j0  = (VEC[i][1] + 1 > LEB + 1) ? VEC[i][1] + 1 : LEB + 1;
            exp = (VEC[i][2] > 0 && j0 <= VEC[i][1] + VEC[i][2] && j0 < lim) ? j0 : lim;
            chk($sformatf("R6/R7 flag vector %0d width", i), w, exp);
        end

        // Restart
        wait_rise();
        restart = 1'b1;
        @(negedge clk);
        restart = 1'b0;
        chk("R8 gate after restart", int'(gate), 0);
        chk("R8 step after restart", int'(ss_step), 0);
        chk("R8 done after restart", int'(ss_done), 0);
        saw = 0;
        for (int i = 0; i < 200; i++) begin @(negedge clk); if (gate) saw = 1; end
        chk("R8 no pulse at rerun step 0", int'(saw), 0);

        // Supply drop during a pulse, then recovery
        wait_step(3, t, saw);
        wait_rise();
        en = 1'b0;
        @(negedge clk);
        chk("R1 gate one clock after en falls", int'(gate), 0);
        chk("R9 step cleared by en low", int'(ss_step), 0);
        saw = 0;
        for (int i = 0; i < 20; i++) begin @(negedge clk); if (gate) saw = 1; end
        chk("R1 gate held low", int'(saw), 0);
        en = 1'b1;
        wait_step(1, t, saw);
        chk("R9 no pulse at step 0 after re-enable", int'(saw), 0);
        chk("R9 first step after re-enable", t, SCYC + 1);

        finish_run();
    end

endmodule